// File: doc/BRIEF.md
# Fixed-Rate Serial Byte Transmitter

This block sends bytes one at a time over a single asynchronous serial line, using a fixed frame of one low start bit, eight data bits (least significant bit first) and one high stop bit, with no parity. It runs from a 48 kHz system clock and sends at 9600 baud. That makes every bit exactly five clock cycles long and a full frame fifty cycles long.

A client offers a byte by holding the data input and raising a one-cycle write strobe. When the transmitter is idle, it copies the byte into an internal frame register and starts the frame in the next cycle. It raises its busy flag for the whole frame. A strobe that arrives while busy is high is thrown away and does not affect the frame in progress. No byte is buffered for later. An active-low clear stops any frame at once and returns the line to idle. The block leaves clear internally only in step with the clock.

Top module: `ser_tx_fixed`

## Requirements
- R1: While no frame is being sent, `tx_line` is 1 and `busy` is 0.
- R2: A frame is a start bit of 0, then `wr_data[0]` through `wr_data[7]` in that order, then a stop bit of 1.
- R3: Each bit lasts exactly 5 clock cycles. `busy` is high for exactly 50 consecutive cycles per frame.
- R4: When `wr_stb` is 1 and `busy` is 0 at a clock edge, `busy` is 1 and `tx_line` is 0 from that edge on.
- R5: A strobe while `busy` is 1 is ignored. The current frame goes on unchanged and no extra frame follows.
- R6: The byte is captured at the accepting edge. Later changes of `wr_data` do not change the frame.
- R7: `busy` falls after the last cycle of the stop bit. A strobe in the first idle cycle starts the next frame, so two frames can be 51 cycles apart with one idle cycle between them.
- R8: `clr_n` = 0 forces `tx_line` to 1 and `busy` to 0 at once, without waiting for a clock, and ends any frame in progress. After `clr_n` rises, strobes are accepted from the third clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 48 kHz |
| clr_n | input | 1 | Asynchronous clear, active low |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Byte to send, sampled with the strobe |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | High while a frame is on the line |

## Verification
The assertions assume that `wr_stb` is a clean synchronous signal. They also assume that checking starts from the internally synchronised clear, so a strobe during the two release cycles is not counted as an accepted write. The stimulus drives every input on the falling clock edge. It releases clear on a falling edge and waits several cycles before the first write. The only strobes it sends while busy are the deliberate ones that test the drop behaviour, and each of those comes well before the final cycle of a frame.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  localparam logic LINE_IDLE  = 1'b1;
  localparam logic LINE_START = 1'b0;
  localparam logic LINE_STOP  = 1'b1;
endpackage

// File: rtl/tx_reset_sync.sv
module tx_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int BIT_CYC = 5,
  localparam int CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run_en,
  output logic bit_end
);
  localparam logic [CW-1:0] LAST = CW'(BIT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (run_en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_end = run_en && (cnt_q == LAST);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
  parameter int DATA_W = 8,
  localparam int FW = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  output logic              line
);
  import ser_tx_pkg::*;

  logic [FW-1:0] frame_q, frame_d;

  always_comb begin
    frame_d = frame_q;
    if (load)       frame_d = {LINE_STOP, data, LINE_START};
    else if (shift) frame_d = {LINE_IDLE, frame_q[FW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '1;
    else        frame_q <= frame_d;
  end

  assign line = frame_q[0];
endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer #(
  parameter int FRAME_BITS = 10,
  localparam int IW = $clog2(FRAME_BITS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic bit_end,
  output logic accept,
  output logic sending,
  output logic shift
);
  import ser_tx_pkg::*;

  localparam logic [IW-1:0] LAST_BIT = IW'(FRAME_BITS - 1);

  tx_state_e       state_q, state_d;
  logic [IW-1:0]   idx_q, idx_d;

  assign sending = (state_q == ST_SEND);
  assign accept  = wr_stb && (state_q == ST_IDLE);
  assign shift   = sending && bit_end;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        if (accept) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (bit_end) begin
          if (idx_q == LAST_BIT) begin
            state_d = ST_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/ser_tx_fixed.sv
module ser_tx_fixed #(
  parameter int CLK_HZ = 48000,
  parameter int BAUD   = 9600,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_line,
  output logic              busy
);
  localparam int BIT_CYC    = CLK_HZ / BAUD;
  localparam int FRAME_BITS = DATA_W + 2;

  logic rst_sync_n;
  logic accept, sending, shift, bit_end;

  tx_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .clr_n(clr_n), .rst_sync_n(rst_sync_n)
  );

  tx_sequencer #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .bit_end(bit_end),
    .accept(accept), .sending(sending), .shift(shift)
  );

  tx_bit_timer #(.BIT_CYC(BIT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .restart(accept), .run_en(sending),
    .bit_end(bit_end)
  );

  tx_frame_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_sync_n), .load(accept), .shift(shift),
    .data(wr_data), .line(tx_line)
  );

  assign busy = sending;
endmodule

// File: rtl/ser_tx_fixed_chk.sv
module ser_tx_fixed_chk #(
  parameter int BIT_CYC   = 5,
  parameter int FRAME_CYC = 50
) (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic tx_line,
  input logic busy
);
  localparam int RW = $clog2(FRAME_CYC + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R1: the line is idle-high whenever no frame is in progress
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  // R4: an accepted strobe starts busy and the start bit at the next edge
  a_r4_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !busy) |=> (busy && !tx_line));

  // R3: a frame holds busy for exactly FRAME_CYC cycles
  a_r3_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RW'(FRAME_CYC)));

  // R3: no frame runs longer than FRAME_CYC cycles
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(FRAME_CYC));

  // R3: the line only changes on bit boundaries while busy
  a_r3_bit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(tx_line)) |-> ((run_q % RW'(BIT_CYC)) == '0));

  // R5: a strobe while busy does not restart the frame
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb && run_q != RW'(FRAME_CYC - 1)) |=>
      (busy && run_q == $past(run_q) + 1'b1));
endmodule

bind ser_tx_fixed ser_tx_fixed_chk #(
  .BIT_CYC(BIT_CYC), .FRAME_CYC(BIT_CYC * FRAME_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb),
  .tx_line(tx_line), .busy(busy)
);

// File: tb/ser_tx_fixed_tb.sv
module ser_tx_fixed_tb;
  logic       clk = 1'b0;
  logic       clr_n;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       tx_line;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int frames_sent = 0;
  int frames_seen = 0;
  int cyc = 0;
  bit mon_go = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ser_tx_fixed u_dut (
    .clk(clk), .clr_n(clr_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .tx_line(tx_line), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: waits for idle, strobes one byte, records expectation
  task automatic send(input logic [7:0] b);
    while (busy) @(negedge clk);
    wr_data = b;
    wr_stb  = 1'b1;
    exp_q.push_back(b);
    frames_sent++;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // monitor: reconstructs each frame at bit centres
  initial begin
    logic [7:0] got;
    logic [7:0] exp_b;
    wait (mon_go);
    forever begin
      @(negedge clk);
      while (!busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(tx_line == 1'b0, "R2 start bit", tx_line, 0);
      for (int k = 0; k < 8; k++) begin
        repeat (5) @(negedge clk);
        got[k] = tx_line;
      end
      repeat (5) @(negedge clk);
      chk(tx_line == 1'b1, "R2 stop bit", tx_line, 1);
      repeat (2) @(negedge clk);
      chk(busy == 1'b1, "R3 busy in last cycle", busy, 1);
      @(negedge clk);
      chk(busy == 1'b0, "R3 busy drop after 50", busy, 0);
      chk(tx_line == 1'b1, "R1 idle after frame", tx_line, 1);
      frames_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected frame", got, 0);
      end else begin
        exp_b = exp_q.pop_front();
        chk(got == exp_b, "R2 R6 frame data", got, exp_b);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int t0;
    int t1;
    clr_n   = 1'b0;
    wr_stb  = 1'b0;
    wr_data = 8'h00;
    repeat (5) @(negedge clk);
    chk(tx_line == 1'b1, "R1 R8 line in clear", tx_line, 1);
    chk(busy == 1'b0, "R1 R8 busy in clear", busy, 0);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_line == 1'b1 && busy == 1'b0, "R1 idle after release", {tx_line, busy}, 2);

    // R8: clear in the middle of a frame
    wr_data = 8'h55;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(busy == 1'b1 && tx_line == 1'b0, "R4 start after accept", {busy, tx_line}, 2);
    repeat (12) @(negedge clk);
    #3 clr_n = 1'b0;
    #2;
    chk(tx_line == 1'b1, "R8 async line high", tx_line, 1);
    chk(busy == 1'b0, "R8 async busy low", busy, 0);
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && tx_line == 1'b1, "R8 frame aborted", {busy, tx_line}, 1);
    repeat (3) @(negedge clk);

    mon_go = 1'b1;
    send(8'hA5);
    send(8'h00);
    send(8'hFF);

    // R7: back-to-back frames
    send(8'h3C);
    t0 = cyc;
    send(8'hC3);
    t1 = cyc;
    chk(busy == 1'b1 && tx_line == 1'b0, "R7 next frame starts", {busy, tx_line}, 2);
    chk((t1 - t0) == 51, "R7 frame spacing", t1 - t0, 51);

    // R5 R6: strobe while busy, and data changes during a frame
    send(8'h96);
    repeat (20) @(negedge clk);
    wr_data = 8'h69;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
    wr_data = 8'hFF;
    chk(busy == 1'b1, "R5 frame continues", busy, 1);
    while (busy) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(frames_seen == frames_sent, "R5 no extra frame", frames_seen, frames_sent);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    send(8'h01);
    send(8'h80);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(frames_seen == frames_sent, "R2 all frames seen", frames_seen, frames_sent);
    chk(tx_line == 1'b1 && busy == 1'b0, "R1 final idle", {tx_line, busy}, 2);
    finish_run();
  end
endmodule